// File: doc/BRIEF.md
# Video Black-Level and Gain Loop Controller

This block closes the digital side of the clamp and automatic gain loops of a two-channel video digitiser. Each sample clock it receives one luma code and one chroma code, each with underflow and overflow flags, together with two timing gates. The sync gate marks the sync tip. The porch gate marks the black reference interval that follows it. From these inputs it forms signed charge-pump commands. The two clamp commands drive luma towards code 64 and chroma towards code 128. The gain command uses the sync tip as its amplitude reference, and it also limits peak white when the active-low peak-white input is asserted.

Three saturating accumulators model the external hold capacitors, so the whole loop, settling included, can run in a digital simulation. A start-up precharge request scales every step by a fixed factor for a set number of lines, so the loops reach their operating point quickly. The two gates must never overlap. If they do, the block raises a flag, keeps the clamp update and drops the gain update.

Top module: `video_loop_ctrl`

## Requirements
- R1: While porchGate is high, yClampCmd is +54 when the luma code is below 64 or yUnder is set, -54 when it is above 64 or yOver is set, and 0 at exactly 64.
- R2: While porchGate is high, cClampCmd is +54 below 128 (or cUnder), -54 above 128 (or cOver), and 0 at 128. Both clamp commands are 0 for any sample taken with porchGate low.
- R3: With peakWhiteN low and syncGate high, gainCmd is +8 on yUnder, +540 on yOver, and -8 for any in-range code.
- R4: With peakWhiteN low and syncGate low, gainCmd is +540 on yOver and 0 otherwise. It is never negative for a sample taken with syncGate low.
- R5: With peakWhiteN high, gainCmd is 0 while syncGate is low. While syncGate is high it is +8 on yUnder and -8 otherwise, overflow included.
- R6: Every command is a 16-bit two's complement value, registered one clock after the sample that produced it. Each accumulator adds the present command at the following clock.
- R7: The 16-bit unsigned accumulators saturate at 256 and 65280 and never wrap.
- R8: A clock with prechargeReq high loads a line counter with 2. While that counter is non-zero, every command magnitude is multiplied by 8. The counter drops by one at each falling edge of syncGate.
- R9: A sample with both gates high sets gateOverlap in the next clock. The clamp commands are still produced, and gainCmd is 0.
- R10: A synchronous active-high reset sets all three accumulators to 32768 and clears all commands and gateOverlap to 0.
- R11: When the accumulator value (upper byte taken as the code) is fed back as the input code during the porch gate, luma settles within one code of 64 and chroma within one code of 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| yCode | input | 8 | Luma sample code |
| yUnder | input | 1 | Luma sample below code 0 |
| yOver | input | 1 | Luma sample above code 255 |
| cCode | input | 8 | Chroma sample code |
| cUnder | input | 1 | Chroma sample below code 0 |
| cOver | input | 1 | Chroma sample above code 255 |
| syncGate | input | 1 | Sync-tip interval gate |
| porchGate | input | 1 | Back-porch (black level) gate |
| peakWhiteN | input | 1 | Peak-white limiting enable, active low |
| prechargeReq | input | 1 | Start-up fast precharge request |
| yClampCmd | output | 16 | Signed luma clamp current command |
| cClampCmd | output | 16 | Signed chroma clamp current command |
| gainCmd | output | 16 | Signed luma gain current command |
| yClampAcc | output | 16 | Luma clamp accumulator |
| cClampAcc | output | 16 | Chroma clamp accumulator |
| gainAcc | output | 16 | Gain accumulator |
| gateOverlap | output | 1 | Both gates were high on the previous sample |

## Verification
The clamp paths are driven with codes below, at and above each target and with the range flags. This shows the exact-target dead zone, and it shows that the flags take precedence over the code. The gain path is tried in every combination of peak-white enable and sync gate with underflow, in-range and overflow samples. That separates sync-tip regulation from the continuous peak limiter, and it shows that overflow without peak-white enable is treated as in range. Overlapping gates, accumulator runs into both limits, a closed loop that feeds the accumulator back as the code, and a two-line precharge window all check behaviour that one-sample patterns do not reach.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  // Strobes from the gate decoder to the datapath.
  typedef struct packed {
    logic clampEn;   // porch interval: clamp comparators active
    logic syncWin;   // sync interval: gain comparator active
    logic peakLimit; // peak-white limiting enabled
    logic boost;     // precharge window: scaled steps
    logic overlap;   // both gates high
  } loopStrobe_t;
endpackage

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
  import vloop_pkg::*;
#(
  parameter int PRE_LINES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        syncGate,
  input  logic        porchGate,
  input  logic        peakWhiteN,
  input  logic        prechargeReq,
  output loopStrobe_t strobe
);
  localparam int CNT_W = $clog2(PRE_LINES + 1);

  logic [CNT_W-1:0] lineCnt;
  logic             prevSync;
  logic             syncFall;

  assign syncFall = prevSync && !syncGate;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineCnt  <= '0;
      prevSync <= 1'b0;
    end else begin
      prevSync <= syncGate;
      if (prechargeReq)
        lineCnt <= CNT_W'(PRE_LINES);
      else if (syncFall && lineCnt != '0)
        lineCnt <= lineCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.clampEn   = porchGate;
    strobe.syncWin   = syncGate;
    strobe.peakLimit = !peakWhiteN;
    strobe.boost     = (lineCnt != '0);
    strobe.overlap   = syncGate && porchGate;
  end
endmodule

// File: rtl/vloop_datapath.sv
module vloop_datapath
  import vloop_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int CMD_W       = 16,
  parameter int ACC_W       = 16,
  parameter int LUMA_BLACK  = 64,
  parameter int CHROMA_MID  = 128,
  parameter int CLAMP_STEP  = 54,
  parameter int GAIN_STEP   = 8,
  parameter int PEAK_STEP   = 540,
  parameter int BOOST       = 8,
  parameter int ACC_LO      = 256,
  parameter int ACC_HI      = 65280
) (
  input  logic                     clk,
  input  logic                     rst,
  input  loopStrobe_t              strobe,
  input  logic [CODE_W-1:0]        yCode,
  input  logic                     yUnder,
  input  logic                     yOver,
  input  logic [CODE_W-1:0]        cCode,
  input  logic                     cUnder,
  input  logic                     cOver,
  output logic signed [CMD_W-1:0]  yClampCmd,
  output logic signed [CMD_W-1:0]  cClampCmd,
  output logic signed [CMD_W-1:0]  gainCmd,
  output logic [ACC_W-1:0]         yClampAcc,
  output logic [ACC_W-1:0]         cClampAcc,
  output logic [ACC_W-1:0]         gainAcc,
  output logic                     gateOverlap
);
  localparam int NLOOP = 3;
  localparam int SUM_W = ((ACC_W > CMD_W) ? ACC_W : CMD_W) + 2;
  localparam logic [CODE_W-1:0] Y_TARGET = CODE_W'(LUMA_BLACK);
  localparam logic [CODE_W-1:0] C_TARGET = CODE_W'(CHROMA_MID);
  localparam logic [ACC_W-1:0]  ACC_MID  = ACC_W'(1) << (ACC_W - 1);
  localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(ACC_LO);
  localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(ACC_HI);

  logic signed [CMD_W-1:0] clampMag, gainMag, peakMag;

  always_comb begin
    clampMag = strobe.boost ? CMD_W'(CLAMP_STEP * BOOST) : CMD_W'(CLAMP_STEP);
    gainMag  = strobe.boost ? CMD_W'(GAIN_STEP * BOOST)  : CMD_W'(GAIN_STEP);
    peakMag  = strobe.boost ? CMD_W'(PEAK_STEP * BOOST)  : CMD_W'(PEAK_STEP);
  end

  function automatic logic signed [CMD_W-1:0] clampStep(
    input logic [CODE_W-1:0]       code,
    input logic                    under,
    input logic                    over,
    input logic [CODE_W-1:0]       target,
    input logic signed [CMD_W-1:0] mag
  );
    logic signed [CMD_W-1:0] res;
    if (under || (!over && code < target)) res = mag;
    else if (over || code > target)        res = -mag;
    else                                   res = '0;
    return res;
  endfunction

  logic signed [CMD_W-1:0] gainNext;

  always_comb begin
    if (strobe.overlap)
      gainNext = '0;
    else if (strobe.syncWin) begin
      if (yUnder)                         gainNext = gainMag;
      else if (yOver && strobe.peakLimit) gainNext = peakMag;
      else                                gainNext = -gainMag;
    end else if (strobe.peakLimit && yOver)
      gainNext = peakMag;
    else
      gainNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      yClampCmd   <= '0;
      cClampCmd   <= '0;
      gainCmd     <= '0;
      gateOverlap <= 1'b0;
    end else begin
      yClampCmd   <= strobe.clampEn ? clampStep(yCode, yUnder, yOver, Y_TARGET, clampMag) : '0;
      cClampCmd   <= strobe.clampEn ? clampStep(cCode, cUnder, cOver, C_TARGET, clampMag) : '0;
      gainCmd     <= gainNext;
      gateOverlap <= strobe.overlap;
    end
  end

  logic signed [CMD_W-1:0] cmdVec [NLOOP];
  logic [ACC_W-1:0]        accVec [NLOOP];

  assign cmdVec[0] = yClampCmd;
  assign cmdVec[1] = cClampCmd;
  assign cmdVec[2] = gainCmd;

  for (genvar i = 0; i < NLOOP; i++) begin : g_acc
    logic [ACC_W-1:0]        accReg;
    logic signed [SUM_W-1:0] sum;

    always_comb sum = $signed({{(SUM_W-ACC_W){1'b0}}, accReg}) + SUM_W'(cmdVec[i]);

    always_ff @(posedge clk) begin
      if (rst)            accReg <= ACC_MID;
      else if (sum < LO_S) accReg <= ACC_W'(ACC_LO);
      else if (sum > HI_S) accReg <= ACC_W'(ACC_HI);
      else                 accReg <= sum[ACC_W-1:0];
    end

    assign accVec[i] = accReg;
  end

  assign yClampAcc = accVec[0];
  assign cClampAcc = accVec[1];
  assign gainAcc   = accVec[2];
endmodule

// File: rtl/video_loop_ctrl.sv
module video_loop_ctrl
  import vloop_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int CMD_W      = 16,
  parameter int ACC_W      = 16,
  parameter int LUMA_BLACK = 64,
  parameter int CHROMA_MID = 128,
  parameter int CLAMP_STEP = 54,
  parameter int GAIN_STEP  = 8,
  parameter int PEAK_STEP  = 540,
  parameter int BOOST      = 8,
  parameter int PRE_LINES  = 2,
  parameter int ACC_LO     = 256,
  parameter int ACC_HI     = 65280
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CODE_W-1:0]       yCode,
  input  logic                    yUnder,
  input  logic                    yOver,
  input  logic [CODE_W-1:0]       cCode,
  input  logic                    cUnder,
  input  logic                    cOver,
  input  logic                    syncGate,
  input  logic                    porchGate,
  input  logic                    peakWhiteN,
  input  logic                    prechargeReq,
  output logic signed [CMD_W-1:0] yClampCmd,
  output logic signed [CMD_W-1:0] cClampCmd,
  output logic signed [CMD_W-1:0] gainCmd,
  output logic [ACC_W-1:0]        yClampAcc,
  output logic [ACC_W-1:0]        cClampAcc,
  output logic [ACC_W-1:0]        gainAcc,
  output logic                    gateOverlap
);
  loopStrobe_t strobe;

  vloop_ctrl #(.PRE_LINES(PRE_LINES)) ctrlI (
    .clk(clk), .rst(rst), .syncGate(syncGate), .porchGate(porchGate),
    .peakWhiteN(peakWhiteN), .prechargeReq(prechargeReq), .strobe(strobe)
  );

  vloop_datapath #(
    .CODE_W(CODE_W), .CMD_W(CMD_W), .ACC_W(ACC_W), .LUMA_BLACK(LUMA_BLACK),
    .CHROMA_MID(CHROMA_MID), .CLAMP_STEP(CLAMP_STEP), .GAIN_STEP(GAIN_STEP),
    .PEAK_STEP(PEAK_STEP), .BOOST(BOOST), .ACC_LO(ACC_LO), .ACC_HI(ACC_HI)
  ) dpI (
    .clk(clk), .rst(rst), .strobe(strobe),
    .yCode(yCode), .yUnder(yUnder), .yOver(yOver),
    .cCode(cCode), .cUnder(cUnder), .cOver(cOver),
    .yClampCmd(yClampCmd), .cClampCmd(cClampCmd), .gainCmd(gainCmd),
    .yClampAcc(yClampAcc), .cClampAcc(cClampAcc), .gainAcc(gainAcc),
    .gateOverlap(gateOverlap)
  );
endmodule

// File: rtl/video_loop_ctrl_chk.sv
module video_loop_ctrl_chk #(
  parameter int CMD_W  = 16,
  parameter int ACC_W  = 16,
  parameter int ACC_LO = 256,
  parameter int ACC_HI = 65280
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    syncGate,
  input logic                    porchGate,
  input logic                    peakWhiteN,
  input logic signed [CMD_W-1:0] yClampCmd,
  input logic signed [CMD_W-1:0] cClampCmd,
  input logic signed [CMD_W-1:0] gainCmd,
  input logic [ACC_W-1:0]        yClampAcc,
  input logic [ACC_W-1:0]        cClampAcc,
  input logic [ACC_W-1:0]        gainAcc,
  input logic                    gateOverlap
);
  assert_clamp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !porchGate |=> (yClampCmd == 0 && cClampCmd == 0));

  assert_gain_sign_R4: assert property (@(posedge clk) disable iff (rst)
    !syncGate |=> (gainCmd >= 0));

  assert_gain_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!syncGate && peakWhiteN) |=> (gainCmd == 0));

  assert_acc_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (yClampCmd > 0) |=> (yClampAcc >= $past(yClampAcc)));

  assert_acc_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    (yClampAcc >= ACC_W'(ACC_LO) && yClampAcc <= ACC_W'(ACC_HI) &&
     cClampAcc >= ACC_W'(ACC_LO) && cClampAcc <= ACC_W'(ACC_HI) &&
     gainAcc   >= ACC_W'(ACC_LO) && gainAcc   <= ACC_W'(ACC_HI)));

  assert_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    (syncGate && porchGate) |=> (gateOverlap && gainCmd == 0));
endmodule

bind video_loop_ctrl video_loop_ctrl_chk #(
  .CMD_W(CMD_W), .ACC_W(ACC_W), .ACC_LO(ACC_LO), .ACC_HI(ACC_HI)
) chkI (
  .clk(clk), .rst(rst), .syncGate(syncGate), .porchGate(porchGate),
  .peakWhiteN(peakWhiteN), .yClampCmd(yClampCmd), .cClampCmd(cClampCmd),
  .gainCmd(gainCmd), .yClampAcc(yClampAcc), .cClampAcc(cClampAcc),
  .gainAcc(gainAcc), .gateOverlap(gateOverlap)
);

// File: tb/video_loop_ctrl_test.sv
`timescale 1ns/1ps
module video_loop_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] yCode = '0, cCode = '0;
  logic yUnder = 1'b0, yOver = 1'b0, cUnder = 1'b0, cOver = 1'b0;
  logic syncGate = 1'b0, porchGate = 1'b0, peakWhiteN = 1'b1, prechargeReq = 1'b0;
  logic signed [15:0] yClampCmd, cClampCmd, gainCmd;
  logic [15:0] yClampAcc, cClampAcc, gainAcc;
  logic gateOverlap;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  video_loop_ctrl uut (
    .clk(clk), .rst(rst), .yCode(yCode), .yUnder(yUnder), .yOver(yOver),
    .cCode(cCode), .cUnder(cUnder), .cOver(cOver), .syncGate(syncGate),
    .porchGate(porchGate), .peakWhiteN(peakWhiteN), .prechargeReq(prechargeReq),
    .yClampCmd(yClampCmd), .cClampCmd(cClampCmd), .gainCmd(gainCmd),
    .yClampAcc(yClampAcc), .cClampAcc(cClampAcc), .gainAcc(gainAcc),
    .gateOverlap(gateOverlap)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    yCode = 8'd100; cCode = 8'd128;
    yUnder = 0; yOver = 0; cUnder = 0; cOver = 0;
    syncGate = 0; porchGate = 0; peakWhiteN = 1; prechargeReq = 0;
  endtask

  task automatic tReset();
    check("R10", "yClampCmd", yClampCmd, 0);
    check("R10", "cClampCmd", cClampCmd, 0);
    check("R10", "gainCmd", gainCmd, 0);
    check("R10", "yClampAcc", yClampAcc, 32768);
    check("R10", "cClampAcc", cClampAcc, 32768);
    check("R10", "gainAcc", gainAcc, 32768);
    check("R10", "gateOverlap", gateOverlap, 0);
  endtask

  task automatic tTiming();
    int a0;
    idle(); porchGate = 1; yCode = 8'd0;
    step();
    check("R6", "cmd one clock after sample", yClampCmd, 54);
    check("R6", "acc not yet updated", yClampAcc, 32768);
    a0 = yClampAcc;
    porchGate = 0;
    step();
    check("R6", "acc adds command", yClampAcc, a0 + 54);
    check("R6", "cmd cleared", yClampCmd, 0);
    step();
    check("R6", "acc holds on zero cmd", yClampAcc, a0 + 54);
  endtask

  task automatic tLuma();
    idle(); porchGate = 1;
    yCode = 8'd10;  step(); check("R1", "luma below", yClampCmd, 54);
    yCode = 8'd64;  step(); check("R1", "luma at target", yClampCmd, 0);
    yCode = 8'd65;  step(); check("R1", "luma above", yClampCmd, -54);
    yCode = 8'd200; yUnder = 1; step(); check("R1", "luma underflow flag", yClampCmd, 54);
    yUnder = 0; yOver = 1; yCode = 8'd0; step(); check("R1", "luma overflow flag", yClampCmd, -54);
    idle();
  endtask

  task automatic tChroma();
    idle(); porchGate = 1;
    cCode = 8'd100; step(); check("R2", "chroma below", cClampCmd, 54);
    cCode = 8'd128; step(); check("R2", "chroma at target", cClampCmd, 0);
    cCode = 8'd129; step(); check("R2", "chroma above", cClampCmd, -54);
    cCode = 8'd10; cOver = 1; step(); check("R2", "chroma overflow flag", cClampCmd, -54);
    cOver = 0; cCode = 8'd0; yCode = 8'd0; porchGate = 0; step();
    check("R2", "chroma idle off porch", cClampCmd, 0);
    check("R2", "luma idle off porch", yClampCmd, 0);
    idle();
  endtask

  task automatic tGain();
    idle(); peakWhiteN = 0; syncGate = 1;
    yUnder = 1; step(); check("R3", "sync underflow", gainCmd, 8);
    yUnder = 0; yCode = 8'd30; step(); check("R3", "sync in range", gainCmd, -8);
    yOver = 1; step(); check("R3", "sync overflow", gainCmd, 540);
    syncGate = 0; step(); check("R4", "limiter overflow", gainCmd, 540);
    yOver = 0; yCode = 8'd250; step(); check("R4", "limiter in range", gainCmd, 0);
    yUnder = 1; step(); check("R4", "limiter underflow", gainCmd, 0);
    yUnder = 0; peakWhiteN = 1; yOver = 1; step(); check("R5", "disabled overflow no sync", gainCmd, 0);
    syncGate = 1; step(); check("R5", "disabled overflow in sync", gainCmd, -8);
    yOver = 0; yUnder = 1; step(); check("R5", "disabled underflow in sync", gainCmd, 8);
    idle(); step();
  endtask

  task automatic tOverlap();
    idle(); peakWhiteN = 0; syncGate = 1; porchGate = 1; yCode = 8'd10; yOver = 0;
    step();
    check("R9", "overlap flag", gateOverlap, 1);
    check("R9", "gain suppressed", gainCmd, 0);
    check("R9", "clamp kept", yClampCmd, 54);
    idle(); step();
    check("R9", "overlap cleared", gateOverlap, 0);
  endtask

  task automatic tSaturate();
    idle(); porchGate = 1; yCode = 8'd0; cCode = 8'd255;
    for (int i = 0; i < 700; i++) step();
    check("R7", "luma upper limit", yClampAcc, 65280);
    check("R7", "chroma lower limit", cClampAcc, 256);
    idle(); step();
  endtask

  task automatic tSettle();
    int yc, cc;
    idle(); porchGate = 1;
    for (int i = 0; i < 1400; i++) begin
      yCode = yClampAcc[15:8];
      cCode = cClampAcc[15:8];
      step();
    end
    yc = yClampAcc[15:8];
    cc = cClampAcc[15:8];
    check("R11", "luma settles near 64", (yc >= 63 && yc <= 65) ? 1 : 0, 1);
    check("R11", "chroma settles near 128", (cc >= 127 && cc <= 129) ? 1 : 0, 1);
    idle(); step();
  endtask

  task automatic tPrecharge();
    idle(); prechargeReq = 1; step();
    prechargeReq = 0; porchGate = 1; yCode = 8'd0; step();
    check("R8", "boosted clamp", yClampCmd, 432);
    porchGate = 0; step();
    syncGate = 1; yCode = 8'd100; step(); check("R8", "boosted gain line 1", gainCmd, -64);
    syncGate = 0; step();
    syncGate = 1; step(); check("R8", "boosted gain line 2", gainCmd, -64);
    syncGate = 0; step();
    syncGate = 1; step(); check("R8", "normal gain after window", gainCmd, -8);
    syncGate = 0; step();
    porchGate = 1; yCode = 8'd0; step(); check("R8", "normal clamp after window", yClampCmd, 54);
    idle(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) step();
    tReset();
    rst = 0;
    step();
    tTiming();
    tLuma();
    tChroma();
    tGain();
    tOverlap();
    tSaturate();
    tSettle();
    tPrecharge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule